// File: doc/BRIEF.md
# DRAM Power-Down Entry/Exit Controller

This block drives the clock-enable pin of a DDR2-class memory device. It watches the commands the controller issues, one event per cycle. From each command it works out how long the device has to stay awake before clock-enable may fall. When the scheduler asks for power-down, the block drops clock-enable on the first legal cycle. That cycle is an idle one, and every timing window opened by earlier commands has run out by then.

While clock-enable is low, the block reports which kind of power-down is in force. If every bank was idle at entry, it is a precharged power-down. If a row was open, it is an active power-down, with a fast or slow exit chosen by a mode-register setting. A wake request raises clock-enable on the next cycle. The block also forces a wake before the stay reaches nine refresh intervals.

After clock-enable rises, a command-ready output stays low until the exit latency for that kind of power-down has elapsed. Every latency is a static input counted in clock cycles.

Top module: `pwrdn_ctrl`

## Requirements
- R1: During and right after reset, `cke` is 1, `cmd_ready` is 1 and `pd_mode` is 2'b00.
- R2: If `pd_req` is high in an awake cycle with no command, no `wake_req` and no open timing window, `cke` is 0 from the next cycle and `cmd_ready` stays 0 while `cke` is 0. A cycle that carries a command never starts power-down.
- R3: After a read or a read with auto-precharge in cycle t, the earliest entry cycle is t + RL + BL/2, so `cke` first reads 0 in cycle t + RL + BL/2 + 1.
- R4: After a write without auto-precharge in cycle t, the earliest entry cycle is t + WL + BL/2 + tWTR.
- R5: After a write with auto-precharge in cycle t, the earliest entry cycle is t + WL + BL/2 + WR.
- R6: After a mode-register write in cycle t, the earliest entry cycle is t + tMRD.
- R7: Activate, precharge and refresh open no window: entry is legal in the cycle right after such a command.
- R8: `pd_mode` is 2'b01 when `banks_idle` was 1 in the entry cycle. Otherwise it is 2'b10 if `cfg_slow_exit` is 0 and 2'b11 if it is 1. `pd_mode` is 2'b00 in every cycle where `cke` is 1.
- R9: A `wake_req` in a cycle where `cke` is 0 makes `cke` 1 in the next cycle.
- R10: If `cke` first reads 1 again in cycle e, `cmd_ready` first reads 1 in cycle e + L. L is `cfg_txp` for mode 2'b01, `cfg_txard` for 2'b10 and `cfg_txards` for 2'b11.
- R11: `pd_req` has no effect while `cmd_ready` is 0 after a wake. If it is held high, entry happens in the first cycle with `cmd_ready` 1, so `cke` falls one cycle later.
- R12: `cke` stays 0 for at most 9·`cfg_trefi` − 1 consecutive cycles. Without a wake, the block raises it after exactly that many cycles.
- R13: Windows that overlap do not shorten each other. A later command with a shorter window leaves the longer remaining wait from an earlier command in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_act | input | 1 | Activate issued this cycle |
| cmd_rd | input | 1 | Read issued this cycle |
| cmd_rda | input | 1 | Read with auto-precharge issued this cycle |
| cmd_wr | input | 1 | Write issued this cycle |
| cmd_wra | input | 1 | Write with auto-precharge issued this cycle |
| cmd_pre | input | 1 | Precharge (single or all) issued this cycle |
| cmd_ref | input | 1 | Auto-refresh issued this cycle |
| cmd_mrs | input | 1 | Mode or extended-mode register write issued this cycle |
| banks_idle | input | 1 | All banks precharged |
| pd_req | input | 1 | Scheduler asks for power-down |
| wake_req | input | 1 | Scheduler needs the device awake |
| cfg_rl | input | LAT_W | Read latency, cycles |
| cfg_wl | input | LAT_W | Write latency, cycles |
| cfg_bl | input | LAT_W | Burst length in beats |
| cfg_twtr | input | LAT_W | Write-to-read turnaround, cycles |
| cfg_wr | input | LAT_W | Write recovery, cycles |
| cfg_tmrd | input | LAT_W | Mode-register command time, cycles |
| cfg_txp | input | LAT_W | Exit latency after precharged power-down |
| cfg_txard | input | LAT_W | Exit latency after fast-exit active power-down |
| cfg_txards | input | LAT_W | Exit latency after slow-exit active power-down |
| cfg_trefi | input | REFI_W | Refresh interval, cycles |
| cfg_slow_exit | input | 1 | Selects slow, low-power exit for active power-down |
| cke | output | 1 | Clock-enable to the device |
| pd_mode | output | 2 | 00 awake, 01 precharged, 10 active fast exit, 11 active slow exit |
| cmd_ready | output | 1 | A command may be issued this cycle |

## Verification
The hardest cases to reach from the ports are a window that a later, shorter command tries to cut, and a power-down request that arrives while the exit latency is still running. The stimulus issues a write and a mode-register write back to back, with the request already high, and counts the cycles to the fall of `cke`. In a separate test it keeps `pd_req` high through a wake, so that a second entry starts on the first ready cycle. The forced exit is reached with a short refresh interval and no wake, and the test counts every low cycle of `cke`.

// File: rtl/pwrdn_pkg.sv
// Shared types for the power-down controller.
// Assumes: two-bit mode code is visible at the top-level port.
package pwrdn_pkg;

    // Power-down flavour reported on pd_mode
    typedef enum logic [1:0] {
        PDM_NONE     = 2'b00,
        PDM_PRE      = 2'b01,
        PDM_ACT_FAST = 2'b10,
        PDM_ACT_SLOW = 2'b11
    } pd_mode_e;

    // Controller phase
    typedef enum logic [1:0] {
        PS_UP   = 2'b00,
        PS_DOWN = 2'b01,
        PS_WAKE = 2'b10
    } pd_state_e;

endpackage

// File: rtl/pwrdn_entry_guard.sv
// Entry guard: tracks the longest remaining blocking window opened by
// read, write, write-with-auto-precharge and mode-register commands.
// Assumes: cmd_take is high only when the device is awake and ready;
// a window of W cycles after a command in cycle t lets entry occur in
// cycle t+W, so the counter loads W-1 and entry needs it at zero.
module pwrdn_entry_guard #(
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_take,
    input  logic             ev_rd,
    input  logic             ev_wr,
    input  logic             ev_wra,
    input  logic             ev_mrs,
    input  logic [LAT_W-1:0] cfg_rl,
    input  logic [LAT_W-1:0] cfg_wl,
    input  logic [LAT_W-1:0] cfg_bl,
    input  logic [LAT_W-1:0] cfg_twtr,
    input  logic [LAT_W-1:0] cfg_wr,
    input  logic [LAT_W-1:0] cfg_tmrd,
    output logic             entry_ok
);
    localparam int BLK_W = LAT_W + 2;
    localparam int NSRC  = 4;

    logic [BLK_W-1:0] win    [NSRC];
    logic [BLK_W-1:0] masked [NSRC];
    logic [NSRC-1:0]  hit;
    logic [BLK_W-1:0] half_bl;
    logic [BLK_W-1:0] load_max;
    logic [BLK_W-1:0] ld_val;
    logic [BLK_W-1:0] dec_val;
    logic [BLK_W-1:0] blk_q;

    // Window length per command class, in cycles from the command
    always_comb begin
        half_bl = {2'b00, cfg_bl} >> 1;
        win[0]  = {2'b00, cfg_rl} + half_bl;
        win[1]  = {2'b00, cfg_wl} + half_bl + {2'b00, cfg_twtr};
        win[2]  = {2'b00, cfg_wl} + half_bl + {2'b00, cfg_wr};
        win[3]  = {2'b00, cfg_tmrd};
    end

    assign hit = {ev_mrs, ev_wra, ev_wr, ev_rd} & {NSRC{cmd_take}};

    // Keep only the windows of commands present this cycle
    for (genvar g = 0; g < NSRC; g++) begin : g_mask
        assign masked[g] = hit[g] ? win[g] : '0;
    end

    // Largest window among this cycle's commands
    always_comb begin
        load_max = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (masked[i] > load_max) load_max = masked[i];
        end
        ld_val  = (load_max == '0) ? '0 : load_max - 1'b1;
        dec_val = (blk_q == '0) ? '0 : blk_q - 1'b1;
    end

    // Blocking counter: drain by one, never below a fresh load
    always_ff @(posedge clk) begin
        if (!rst_n) blk_q <= '0;
        else        blk_q <= (ld_val > dec_val) ? ld_val : dec_val;
    end

    assign entry_ok = (blk_q == '0);

    // R13: a new command never leaves less wait than its own window
    a_r13_keep_largest: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit) |=> (blk_q >= $past(ld_val)));

    // R3: with no new command the window drains one cycle at a time
    a_r3_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|hit) && blk_q != '0) |=> (blk_q == $past(blk_q) - 1'b1));

endmodule

// File: rtl/pwrdn_stay_limit.sv
// Stay limiter: counts cycles spent in power-down and flags the last
// cycle allowed before MULT refresh intervals would be reached.
// Assumes: pd_active is high exactly in the cycles where CKE is low.
module pwrdn_stay_limit #(
    parameter int REFI_W = 16,
    parameter int MULT   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_active,
    input  logic [REFI_W-1:0] cfg_trefi,
    output logic              limit_hit
);
    localparam int STAY_W = REFI_W + $clog2(MULT + 1);

    logic [STAY_W-1:0] lim;
    logic [STAY_W-1:0] cnt_q;

    // Absolute stay limit in cycles
    assign lim = STAY_W'(cfg_trefi) * STAY_W'(MULT);

    // Cycle index within the current stay, 1 on the first low cycle
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= STAY_W'(1);
        else if (pd_active) cnt_q <= cnt_q + 1'b1;
        else                cnt_q <= STAY_W'(1);
    end

    // Last permitted low cycle is lim-1
    assign limit_hit = pd_active && (({1'b0, cnt_q} + 1'b1) >= {1'b0, lim});

    // R12: the stay index never reaches the limit
    a_r12_stay_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_active && lim > STAY_W'(1)) |-> (cnt_q < lim));

endmodule

// File: rtl/pwrdn_exit_timer.sv
// Exit timer: after CKE rises, counts the exit latency down and
// reports when a command may be issued.
// Assumes: start pulses on the edge that raises CKE; a latency of 0
// behaves as 1.
module pwrdn_exit_timer #(
    parameter int LAT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LAT_W-1:0] lat,
    output logic             done
);
    logic [LAT_W-1:0] cnt_q;

    // Load latency-1 on start, then count to zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start)          cnt_q <= (lat == '0) ? '0 : lat - 1'b1;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

    // R10: the exit count moves by exactly one per cycle
    a_r10_exit_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/pwrdn_ctrl.sv
// Power-down controller top: decides the cycle CKE falls, the flavour
// of power-down, the cycle CKE rises, and when commands are allowed.
// Assumes: command inputs are one-cycle events from the scheduler;
// configuration inputs change only while the device is awake and idle.
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int LAT_W  = 6,
    parameter int REFI_W = 16,
    parameter int MULT   = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_act,
    input  logic              cmd_rd,
    input  logic              cmd_rda,
    input  logic              cmd_wr,
    input  logic              cmd_wra,
    input  logic              cmd_pre,
    input  logic              cmd_ref,
    input  logic              cmd_mrs,
    input  logic              banks_idle,
    input  logic              pd_req,
    input  logic              wake_req,
    input  logic [LAT_W-1:0]  cfg_rl,
    input  logic [LAT_W-1:0]  cfg_wl,
    input  logic [LAT_W-1:0]  cfg_bl,
    input  logic [LAT_W-1:0]  cfg_twtr,
    input  logic [LAT_W-1:0]  cfg_wr,
    input  logic [LAT_W-1:0]  cfg_tmrd,
    input  logic [LAT_W-1:0]  cfg_txp,
    input  logic [LAT_W-1:0]  cfg_txard,
    input  logic [LAT_W-1:0]  cfg_txards,
    input  logic [REFI_W-1:0] cfg_trefi,
    input  logic              cfg_slow_exit,
    output logic              cke,
    output logic [1:0]        pd_mode,
    output logic              cmd_ready
);
    pd_state_e        state_q;
    pd_state_e        state_d;
    pd_mode_e         mode_q;
    pd_mode_e         mode_sel;
    logic             any_cmd;
    logic             cmd_take;
    logic             entry_ok;
    logic             entry_go;
    logic             limit_hit;
    logic             exit_go;
    logic             exit_done;
    logic [LAT_W-1:0] exit_lat;

    // Any command on the bus this cycle makes it a non-idle cycle
    assign any_cmd  = cmd_act | cmd_rd | cmd_rda | cmd_wr | cmd_wra |
                      cmd_pre | cmd_ref | cmd_mrs;
    assign cmd_take = (state_q == PS_UP);

    pwrdn_entry_guard #(.LAT_W(LAT_W)) u_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_take (cmd_take),
        .ev_rd    (cmd_rd | cmd_rda),
        .ev_wr    (cmd_wr),
        .ev_wra   (cmd_wra),
        .ev_mrs   (cmd_mrs),
        .cfg_rl   (cfg_rl),
        .cfg_wl   (cfg_wl),
        .cfg_bl   (cfg_bl),
        .cfg_twtr (cfg_twtr),
        .cfg_wr   (cfg_wr),
        .cfg_tmrd (cfg_tmrd),
        .entry_ok (entry_ok)
    );

    pwrdn_stay_limit #(.REFI_W(REFI_W), .MULT(MULT)) u_stay (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_active (state_q == PS_DOWN),
        .cfg_trefi (cfg_trefi),
        .limit_hit (limit_hit)
    );

    // Flavour chosen from bank status and the exit-speed setting
    always_comb begin
        if (banks_idle)         mode_sel = PDM_PRE;
        else if (cfg_slow_exit) mode_sel = PDM_ACT_SLOW;
        else                    mode_sel = PDM_ACT_FAST;
    end

    // Exit latency for the flavour in force
    always_comb begin
        case (mode_q)
            PDM_ACT_FAST: exit_lat = cfg_txard;
            PDM_ACT_SLOW: exit_lat = cfg_txards;
            default:      exit_lat = cfg_txp;
        endcase
    end

    assign entry_go = (state_q == PS_UP) && pd_req && !any_cmd &&
                      !wake_req && entry_ok;
    assign exit_go  = (state_q == PS_DOWN) && (wake_req || limit_hit);

    pwrdn_exit_timer #(.LAT_W(LAT_W)) u_exit (
        .clk   (clk),
        .rst_n (rst_n),
        .start (exit_go),
        .lat   (exit_lat),
        .done  (exit_done)
    );

    // Phase transitions
    always_comb begin
        state_d = state_q;
        case (state_q)
            PS_UP:   if (entry_go)  state_d = PS_DOWN;
            PS_DOWN: if (exit_go)   state_d = PS_WAKE;
            PS_WAKE: if (exit_done) state_d = PS_UP;
            default: state_d = PS_UP;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_UP;
        else        state_q <= state_d;
    end

    // Flavour captured on the entry edge
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= PDM_NONE;
        else if (entry_go) mode_q <= mode_sel;
    end

    assign cke       = (state_q != PS_DOWN);
    assign cmd_ready = (state_q == PS_UP);
    assign pd_mode   = (state_q == PS_DOWN) ? mode_q : PDM_NONE;

    // R2: CKE only falls after a cycle the guard cleared
    a_r2_entry_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> $past(entry_ok));

    // R2: no command is allowed while CKE is low
    a_r2_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !cmd_ready);

    // R8: mode code reads as awake whenever CKE is high
    a_r8_mode_awake: assert property (@(posedge clk) disable iff (!rst_n)
        cke |-> (pd_mode == 2'b00));

    // R9: a wake request while down raises CKE on the next cycle
    a_r9_wake_next: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && wake_req) |=> cke);

    // R11: no re-entry while the exit latency runs
    a_r11_no_reentry: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cmd_ready) |=> cke);

endmodule

// File: tb/tb_pwrdn_ctrl.sv
// Directed bench for the power-down controller.
module tb_pwrdn_ctrl;
    localparam int LAT_W  = 6;
    localparam int REFI_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_act = 0, cmd_rd = 0, cmd_rda = 0, cmd_wr = 0;
    logic cmd_wra = 0, cmd_pre = 0, cmd_ref = 0, cmd_mrs = 0;
    logic banks_idle = 1, pd_req = 0, wake_req = 0;
    logic [LAT_W-1:0]  cfg_rl = 5, cfg_wl = 4, cfg_bl = 8, cfg_twtr = 2;
    logic [LAT_W-1:0]  cfg_wr = 3, cfg_tmrd = 2, cfg_txp = 3;
    logic [LAT_W-1:0]  cfg_txard = 2, cfg_txards = 6;
    logic [REFI_W-1:0] cfg_trefi = 20;
    logic              cfg_slow_exit = 0;
    logic              cke;
    logic [1:0]        pd_mode;
    logic              cmd_ready;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pwrdn_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_act(cmd_act), .cmd_rd(cmd_rd), .cmd_rda(cmd_rda),
        .cmd_wr(cmd_wr), .cmd_wra(cmd_wra), .cmd_pre(cmd_pre),
        .cmd_ref(cmd_ref), .cmd_mrs(cmd_mrs),
        .banks_idle(banks_idle), .pd_req(pd_req), .wake_req(wake_req),
        .cfg_rl(cfg_rl), .cfg_wl(cfg_wl), .cfg_bl(cfg_bl),
        .cfg_twtr(cfg_twtr), .cfg_wr(cfg_wr), .cfg_tmrd(cfg_tmrd),
        .cfg_txp(cfg_txp), .cfg_txard(cfg_txard), .cfg_txards(cfg_txards),
        .cfg_trefi(cfg_trefi), .cfg_slow_exit(cfg_slow_exit),
        .cke(cke), .pd_mode(pd_mode), .cmd_ready(cmd_ready)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_cmd(input int sel, input logic v);
        case (sel)
            0: cmd_act = v;  1: cmd_rd  = v;  2: cmd_rda = v;  3: cmd_wr  = v;
            4: cmd_wra = v;  5: cmd_pre = v;  6: cmd_ref = v;  default: cmd_mrs = v;
        endcase
    endtask

    // Let every window expire while awake and idle
    task automatic settle();
        pd_req = 0; wake_req = 0;
        repeat (16) @(negedge clk);
    endtask

    // Count edges from a command until CKE is seen low
    task automatic count_to_low(output int n);
        n = 0;
        while (n < 60) begin
            @(posedge clk); n++;
            @(negedge clk);
            if (!cke) break;
        end
    endtask

    // One command with the request already high; check wait and mode
    task automatic t_entry(input int sel, input int exp_k,
                           input int exp_mode, input string tag);
        int n;
        settle();
        set_cmd(sel, 1'b1); pd_req = 1;
        @(posedge clk); @(negedge clk);
        set_cmd(sel, 1'b0);
        chk({tag, " cke high on command cycle (R2)"}, cke, 1);
        count_to_low(n);
        pd_req = 0;
        chk({tag, " entry wait"}, n, exp_k);
        chk({tag, " ready low in power-down (R2)"}, cmd_ready, 0);
        chk({tag, " mode (R8)"}, pd_mode, exp_mode);
    endtask

    // Wake from power-down; check CKE and exit latency
    task automatic t_wake(input int exp_l, input string tag);
        int n;
        wake_req = 1;
        @(posedge clk); @(negedge clk);
        wake_req = 0;
        chk({tag, " cke up next cycle (R9)"}, cke, 1);
        chk({tag, " mode cleared when awake (R8)"}, pd_mode, 0);
        n = 0;
        while (!cmd_ready && n < 60) begin
            @(posedge clk); @(negedge clk); n++;
        end
        chk({tag, " exit latency (R10)"}, n, exp_l);
    endtask

    // R13: write then mode-register write, shorter window must not win
    task automatic t_overlap();
        int n;
        settle();
        banks_idle = 0; cmd_wr = 1; pd_req = 1;
        @(posedge clk); @(negedge clk);
        cmd_wr = 0; cmd_mrs = 1;
        @(posedge clk); @(negedge clk);
        cmd_mrs = 0;
        count_to_low(n);
        pd_req = 0;
        chk("R13 overlap wait from second command", n, 9);
        t_wake(2, "R13");
    endtask

    // R11: request held through the exit; re-entry on first ready cycle
    task automatic t_hold_req();
        banks_idle = 1;
        t_entry(0, 1, 1, "R11 setup");
        pd_req = 1; wake_req = 1;
        @(posedge clk); @(negedge clk);
        wake_req = 0;
        chk("R11 cke high after wake", cke, 1);
        for (int i = 1; i <= 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R11 cke held high during exit", cke, 1);
        end
        chk("R11 ready after exit latency", cmd_ready, 1);
        @(posedge clk); @(negedge clk);
        chk("R11 re-entry right after ready", cke, 0);
        pd_req = 0;
        t_wake(3, "R11 final");
    endtask

    // R12: no wake; stay limited to 9*tREFI-1 cycles
    task automatic t_limit();
        int n;
        int m;
        banks_idle = 1;
        t_entry(5, 1, 1, "R12 setup");
        n = 1;
        while (n < 400) begin
            @(posedge clk); @(negedge clk);
            if (cke) break;
            n++;
        end
        chk("R12 low cycles before forced exit", n, 9 * 20 - 1);
        m = 0;
        while (!cmd_ready && m < 60) begin
            @(posedge clk); @(negedge clk); m++;
        end
        chk("R12 exit latency after forced exit (R10)", m, 3);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 50000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 cke in reset", cke, 1);
        chk("R1 ready in reset", cmd_ready, 1);
        rst_n = 1;
        @(negedge clk);
        chk("R1 cke after reset", cke, 1);
        chk("R1 ready after reset", cmd_ready, 1);
        chk("R1 mode after reset", pd_mode, 0);

        banks_idle = 1;
        t_entry(0, 1, 1, "R7 activate");   t_wake(3, "R7 activate");
        t_entry(5, 1, 1, "R7 precharge");  t_wake(3, "R7 precharge");
        t_entry(6, 1, 1, "R7 refresh");    t_wake(3, "R7 refresh");
        banks_idle = 0;
        t_entry(1, 9, 2, "R3 read");       t_wake(2, "R3 read");
        t_entry(3, 10, 2, "R4 write");     t_wake(2, "R4 write");
        banks_idle = 1;
        t_entry(2, 9, 1, "R3 read ap");    t_wake(3, "R3 read ap");
        t_entry(4, 11, 1, "R5 write ap");  t_wake(3, "R5 write ap");
        t_entry(7, 2, 1, "R6 mode reg");   t_wake(3, "R6 mode reg");
        banks_idle = 0; cfg_slow_exit = 1;
        t_entry(0, 1, 3, "R8 slow");       t_wake(6, "R8 slow");
        cfg_slow_exit = 0;
        t_overlap();
        t_hold_req();
        t_limit();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule